// File: doc/BRIEF.md
# Watchdog Timer with Guarded Disable

This block is a watchdog counter for a microcontroller-class chip. It counts ticks of a slow watchdog oscillator, which arrives as a single-cycle enable pulse in the system clock domain. When the count reaches a limit chosen by a 3-bit prescale field, the block emits a one-clock system reset pulse and starts counting again from zero. Software keeps the chip alive by issuing a kick strobe, which clears the count, before the limit is reached.

Software reaches the watchdog through a byte-wide control register, written with a write strobe and always readable. Setting the enable bit takes a single write. Clearing it is guarded, so that a runaway program cannot switch the watchdog off by accident. One write must raise a turn-off-enable bit and the enable bit together. This opens a window of four system clocks. A write that clears the enable bit takes effect only inside that window.

Top module: `wdt_guard`

## Requirements
- R1: After the asynchronous reset, `ctl_rdata` reads 0x00 and `sys_rst_pulse` is low. The enable bit, the turn-off-enable bit, the prescale field and the counter are all cleared.
- R2: `ctl_rdata` = {3'b000, toe, en, ps}:
  - bit 4 is the turn-off-enable bit (toe);
  - bit 3 is the enable bit (en);
  - bits 2..0 are the prescale field (ps).

  Every write loads ps from bits 2..0. A write with bit 3 = 1 sets en without any unlock.
- R3: A write with bits 4 and 3 both 1 sets toe and en. A write with bit 4 = 1 and bit 3 = 0 never sets toe.
- R4: toe clears itself after four clocks. A write with bit 3 = 0 on any of the four clock edges that follow the unlock write clears both en and toe.
- R5: A write with bit 3 = 0 while toe is 0 leaves en unchanged.
- R6: While enabled, the count limit is 2^(BASE_LOG2+ps) oscillator ticks. With the default BASE_LOG2 = 14, code 0 gives 16384 ticks and each higher code doubles the limit, up to 2048K at code 7. On the edge after the count reaches the limit, `sys_rst_pulse` is high for exactly one clock and the count returns to 0.
- R7: The count advances only on clocks where `osc_tick` is high.
- R8: `kick` clears the count. Enabling the watchdog without a kick resumes counting from the held value.
- R9: While en is 0, the count holds and `sys_rst_pulse` stays low.
- R10: If a prescale write lowers the limit to or below the current count while enabled, a reset pulse follows on the next clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-clock watchdog oscillator tick |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write data |
| kick | input | 1 | Counter clear strobe |
| ctl_rdata | output | 8 | Control register read value |
| sys_rst_pulse | output | 1 | One-clock system reset request |

## Verification
On every cycle, the assertions check four things:
- en falls only through a write inside an open window;
- toe never stands without en;
- a reset pulse needs the watchdog to have been enabled and is never two clocks long;
- a disabled counter holds, and a kick always leaves the counter at zero.

The exact timeout length for each prescale code, the four-edge window boundary, resumption from a held count, and the immediate pulse after the limit is lowered are shown only by the bench's scenarios. The bench measures clocks from the enabling write to the pulse in those scenarios.

// File: rtl/wdt_guard.sv
module wdt_guard #(
  parameter int BASE_LOG2 = 14,
  parameter int WIN       = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       osc_tick,
  input  logic       ctl_we,
  input  logic [7:0] ctl_wdata,
  input  logic       kick,
  output logic [7:0] ctl_rdata,
  output logic       sys_rst_pulse
);
  localparam int PS_W = 3;
  localparam int CW   = BASE_LOG2 + (1 << PS_W);
  localparam int WW   = (WIN > 1) ? $clog2(WIN) : 1;
  localparam logic [WW-1:0] WIN_LD = WW'(WIN - 1);

  logic            en, toe;
  logic [PS_W-1:0] ps;
  logic [WW-1:0]   win;
  logic [CW-1:0]   cnt, limit;
  logic            unlock, expired, unused_hi;

  assign unused_hi = ^ctl_wdata[7:5];
  assign unlock    = ctl_we & ctl_wdata[4] & ctl_wdata[3];
  assign limit     = CW'(1) << (BASE_LOG2 + 32'(ps));
  assign expired   = en & (cnt >= limit);
  assign ctl_rdata = {3'b000, toe, en, ps};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en  <= 1'b0;
      toe <= 1'b0;
      win <= '0;
      ps  <= '0;
    end else begin
      if (toe) begin
        if (win == '0) toe <= 1'b0;
        else           win <= win - 1'b1;
      end
      if (ctl_we) begin
        ps <= ctl_wdata[PS_W-1:0];
        if (unlock) begin
          en  <= 1'b1;
          toe <= 1'b1;
          win <= WIN_LD;
        end else if (ctl_wdata[3]) begin
          en <= 1'b1;
        end else if (toe) begin
          en  <= 1'b0;
          toe <= 1'b0;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt           <= '0;
      sys_rst_pulse <= 1'b0;
    end else begin
      sys_rst_pulse <= expired;
      if (expired || kick)     cnt <= '0;
      else if (en && osc_tick) cnt <= cnt + 1'b1;
    end
  end

  // R4 R5
  en_fall_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en) |-> $past(toe && ctl_we && !ctl_wdata[3]));

  // R3
  toe_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    toe |-> en);

  // R3
  unlock_opens_chk: assert property (@(posedge clk) disable iff (!rst_n)
    unlock |=> (toe && en));

  // R9
  pulse_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |-> $past(en));

  // R6
  pulse_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sys_rst_pulse |=> !sys_rst_pulse);

  // R9
  hold_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !kick) |=> $stable(cnt));

  // R8
  kick_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    kick |=> (cnt == '0));
endmodule

// File: tb/wdt_guard_bench.sv
module wdt_guard_bench;
  localparam int CLK_PERIOD = 10;
  localparam int SB = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0, kick = 1'b0;
  logic [7:0] wdata = 8'h00, rdata;
  logic pulse;
  logic d_we = 1'b0, d_pulse;
  logic [7:0] d_rdata;
  int checks = 0, errors = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_guard #(.BASE_LOG2(SB)) u_wdt_guard (
    .clk(clk), .rst_n(rst_n), .osc_tick(tick), .ctl_we(we), .ctl_wdata(wdata),
    .kick(kick), .ctl_rdata(rdata), .sys_rst_pulse(pulse));

  wdt_guard u_wdt_dflt (
    .clk(clk), .rst_n(rst_n), .osc_tick(1'b1), .ctl_we(d_we), .ctl_wdata(8'h08),
    .kick(1'b0), .ctl_rdata(d_rdata), .sys_rst_pulse(d_pulse));

  // Reference model built from the requirements.
  logic m_en, m_toe, m_pulse;
  logic [2:0] m_ps;
  int m_win, m_cnt;

  function automatic int lim(input logic [2:0] p);
    return (1 << SB) << p;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_en <= 0; m_toe <= 0; m_win <= 0; m_ps <= 0; m_cnt <= 0; m_pulse <= 0;
    end else begin
      logic ex;
      ex = m_en && (m_cnt >= lim(m_ps));
      m_pulse <= ex;
      if (ex || kick) m_cnt <= 0;
      else if (m_en && tick) m_cnt <= m_cnt + 1;
      if (m_toe) begin
        if (m_win == 0) m_toe <= 0; else m_win <= m_win - 1;
      end
      if (we) begin
        m_ps <= wdata[2:0];
        if (wdata[4] && wdata[3]) begin m_en <= 1; m_toe <= 1; m_win <= 3; end
        else if (wdata[3]) m_en <= 1;
        else if (m_toe) begin m_en <= 0; m_toe <= 0; end
      end
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    check("R2 ctl_rdata vs model", int'(rdata), int'({3'b000, m_toe, m_en, m_ps}));
    check("R6 pulse vs model", int'(pulse), int'(m_pulse));
  endtask

  task automatic wr(input logic [7:0] d, input logic k);
    we = 1'b1; wdata = d; kick = k;
    step();
    we = 1'b0; kick = 1'b0;
  endtask

  task automatic clocks_to_pulse(output int n, input int maxn);
    n = 0;
    do begin step(); n++; end while (!pulse && n < maxn);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset rdata", int'(rdata), 0);
    check("R1 reset pulse", int'(pulse), 0);
    rst_n = 1'b1;
    step();

    // R2 plain enable and layout
    wr(8'hEB, 1'b0);
    check("R2 enable write, high bits read 0", int'(rdata), 8'h0B);
    // R3 + R5: bit4 alone neither unlocks nor disables
    wr(8'h10, 1'b0);
    check("R3 bit4 without bit3 no unlock", int'(rdata), 8'h08);
    // R4 window closes after four clocks
    wr(8'h18, 1'b0);
    check("R3 unlock sets toe and en", int'(rdata), 8'h18);
    repeat (4) step();
    check("R4 toe self-clears", int'(rdata), 8'h08);
    wr(8'h00, 1'b0);
    check("R5 late disable rejected", int'(rdata), 8'h08);
    // R4 disable on fourth edge after unlock
    wr(8'h18, 1'b0);
    repeat (3) step();
    wr(8'h00, 1'b0);
    check("R4 disable on last window edge", int'(rdata), 8'h00);
    wr(8'h13, 1'b0);
    check("R3 bit4 alone from disabled", int'(rdata), 8'h03);
    wr(8'h00, 1'b0);

    // R6 timeout per code
    tick = 1'b1;
    for (int p = 0; p < 3; p++) begin
      wr(8'h08 | 8'(p), 1'b1);
      clocks_to_pulse(n, 5000);
      check($sformatf("R6 timeout code %0d", p), n, lim(3'(p)) + 1);
      step();
      check("R6 pulse one clock", int'(pulse), 0);
    end

    // R7 no ticks, no progress
    tick = 1'b0;
    wr(8'h08, 1'b1);
    n = 0;
    repeat (100) begin step(); if (pulse) n++; end
    check("R7 no pulse without ticks", n, 0);

    // R8 + R9 held count resumes
    tick = 1'b1;
    wr(8'h08, 1'b1);
    repeat (10) step();
    tick = 1'b0;
    wr(8'h18, 1'b0);
    wr(8'h00, 1'b0);
    tick = 1'b1;
    n = 0;
    repeat (60) begin step(); if (pulse) n++; end
    check("R9 disabled no pulse", n, 0);
    wr(8'h08, 1'b0);
    clocks_to_pulse(n, 100);
    check("R8 resume from held count", n, lim(3'd0) - 10 + 1);
    // R8 kick mid-count
    step();
    repeat (8) step();
    kick = 1'b1; step(); kick = 1'b0;
    clocks_to_pulse(n, 100);
    check("R8 kick restarts count", n, lim(3'd0) + 1);

    // R10 prescale lowered below count
    wr(8'h0B, 1'b1);
    repeat (40) step();
    wr(8'h08, 1'b0);
    clocks_to_pulse(n, 100);
    check("R10 immediate pulse after lower limit", n, 1);

    // R6 default 16K limit on the second instance
    d_we = 1'b1; @(negedge clk); d_we = 1'b0;
    n = 0;
    do begin @(negedge clk); n++; end while (!d_pulse && n < 20000);
    check("R6 default code 0 is 16384 ticks", n, 16384 + 1);

    // Random phase
    for (int i = 0; i < 4000; i++) begin
      logic [2:0] p;
      int sel;
      p = 3'($urandom % 3);
      sel = int'($urandom % 4);
      tick = ($urandom % 2) == 0;
      kick = ($urandom % 40) == 0;
      we = ($urandom % 8) == 0;
      case (sel)
        0: wdata = {5'b00011, p};
        1: wdata = {5'b00000, p};
        2: wdata = {5'b00001, p};
        default: wdata = 8'($urandom);
      endcase
      step();
    end
    we = 1'b0; kick = 1'b0;
    step();

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule